// File: doc/BRIEF.md
# Selectable-Source Tone Channel

This block produces a single square-wave tone bit for a simple sound path. All of its timing comes from two clock-enable strobes that pulse on the one system clock: a slow strobe and a fast strobe. A two-bit source select picks one of four tick streams built from those strobes. An octave bit can then thin the chosen stream by eight. A 7-bit shift-register-sequence counter divides the resulting ticks by an amount set by a 7-bit frequency word. A toggle stage turns each terminal event of that counter into a half-period of a 50% duty output.

Software sets the source, the octave bit and the frequency word, and then raises the enable. While the enable is low the output stays low and every divider sits in a fixed starting state, so each burst of tone starts from the same phase. A new frequency word is only picked up when the counter reloads, so a half-period that is already under way is never cut short.

Top module: `tone_channel`

## Requirements
- R1: After a synchronous reset the output `tone_o` is 0.
- R2: With `src_sel_i` = 2'b00, every `slow_tick_i` pulse is one source tick.
- R3: With `src_sel_i` = 2'b01, every second `slow_tick_i` pulse is a source tick, counting pulses from the cycle the enable rose.
- R4: With `src_sel_i` = 2'b10, every `fast_tick_i` pulse is one source tick.
- R5: With `src_sel_i` = 2'b11, every sixteenth `fast_tick_i` pulse is a source tick, counting pulses from the cycle the enable rose.
- R6: With `octave_i` = 1 only every eighth source tick reaches the period counter. With `octave_i` = 0 every source tick reaches it.
- R7: The period counter steps as a 7-bit sequence whose next value is {s[5:0], s[6]^s[5]}. A tick that finds the state at 7'h7F reloads the frequency word and toggles `tone_o` on that same clock edge. A half-period therefore lasts (steps from the word to 7'h7F) + 1 ticks, and a word of 7'h7F toggles the output on every tick.
- R8: A frequency word of 7'h00 acts as 7'h7F, so the counter state is never all zeros.
- R9: While `enable_i` is 0, `tone_o` is 0 from the next clock edge on. All dividers are cleared and the counter holds the reload value of the current word.
- R10: A change of `freq_i` in the middle of a half-period leaves that half-period's length unchanged. The new word applies from the next reload.
- R11: In a cycle with no strobe on either input, `tone_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Channel run enable |
| slow_tick_i | input | 1 | One-cycle strobe of the low-speed timebase |
| fast_tick_i | input | 1 | One-cycle strobe of the high-speed timebase |
| src_sel_i | input | 2 | Source select: 00 slow, 01 slow/2, 10 fast, 11 fast/16 |
| octave_i | input | 1 | 1 divides the selected source by eight |
| freq_i | input | 7 | Frequency word (reload value of the period counter) |
| tone_o | output | 1 | Square-wave tone output |

## Verification
The source mux and the prescaler are combinational, so a strobe that produces a terminal tick changes `tone_o` at the same rising edge that samples it. Disabling forces the output low at the next edge. The bench drives inputs on the falling edge. Its behavioural model steps on each rising edge using those settled inputs, and the output is compared with the model on the following falling edge, one full cycle after the stimulus. Counted-toggle checks over fixed windows, each started from a fresh enable, confirm the divide ratios of R5, R6 and R7 independently of the model.

// File: rtl/tone_pkg.sv
package tone_pkg;

    localparam int SEQ_W      = 7;
    localparam int FAST_DIV   = 16;
    localparam int OCT_DIV    = 8;

    typedef enum logic [1:0] {
        SRC_SLOW      = 2'b00,
        SRC_SLOW_HALF = 2'b01,
        SRC_FAST      = 2'b10,
        SRC_FAST_SIXT = 2'b11
    } src_sel_e;

    typedef logic [SEQ_W-1:0] seq_t;

    // Pulses travelling down the divider chain in one cycle
    typedef struct packed {
        logic src;
        logic scaled;
        logic term;
    } tick_chain_t;

    localparam seq_t SEQ_TERMINAL = '1;

    // Fibonacci step for x^7 + x^6 + 1
    function automatic seq_t seq_next(input seq_t s);
        return {s[SEQ_W-2:0], s[SEQ_W-1] ^ s[SEQ_W-2]};
    endfunction

    // An all-zero word would lock the sequence, so it is read as the terminal value
    function automatic seq_t seq_reload(input seq_t w);
        return (w == '0) ? SEQ_TERMINAL : w;
    endfunction

endpackage

// File: rtl/tone_src_mux.sv
module tone_src_mux
    import tone_pkg::*;
#(
    parameter int SLOW_DIV = 2,
    parameter int HI_DIV   = FAST_DIV
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     slow_tick,
    input  logic     fast_tick,
    input  src_sel_e sel,
    output logic     src_tick
);
    localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam int FW = (HI_DIV > 1) ? $clog2(HI_DIV) : 1;
    localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_DIV - 1);
    localparam logic [FW-1:0] FAST_LAST = FW'(HI_DIV - 1);

    logic [SW-1:0] slow_cnt;
    logic [FW-1:0] fast_cnt;
    logic          slow_div_tick;
    logic          fast_div_tick;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            slow_cnt <= '0;
            fast_cnt <= '0;
        end else begin
            if (slow_tick)
                slow_cnt <= (slow_cnt == SLOW_LAST) ? '0 : slow_cnt + 1'b1;
            if (fast_tick)
                fast_cnt <= (fast_cnt == FAST_LAST) ? '0 : fast_cnt + 1'b1;
        end
    end

    assign slow_div_tick = slow_tick && (slow_cnt == SLOW_LAST);
    assign fast_div_tick = fast_tick && (fast_cnt == FAST_LAST);

    always_comb begin
        unique case (sel)
            SRC_SLOW:      src_tick = slow_tick;
            SRC_SLOW_HALF: src_tick = slow_div_tick;
            SRC_FAST:      src_tick = fast_tick;
            SRC_FAST_SIXT: src_tick = fast_div_tick;
            default:       src_tick = 1'b0;
        endcase
    end

    // R2 R3 R4 R5: a source tick always rides on a strobe
    assert_src_from_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        src_tick |-> (slow_tick || fast_tick));

endmodule

// File: rtl/tone_octave.sv
module tone_octave
    import tone_pkg::*;
#(
    parameter int DIV = OCT_DIV
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic octave,
    input  logic in_tick,
    output logic out_tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (in_tick)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assign out_tick = octave ? (in_tick && cnt == LAST) : in_tick;

    // R6: the prescaler never invents a tick
    assert_octave_subset_R6: assert property (@(posedge clk) disable iff (rst)
        out_tick |-> in_tick);

endmodule

// File: rtl/tone_seq_div.sv
module tone_seq_div
    import tone_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    input  seq_t freq,
    output logic term
);
    seq_t state;

    assign term = tick && (state == SEQ_TERMINAL);

    always_ff @(posedge clk) begin
        if (rst || !run)
            state <= seq_reload(freq);
        else if (tick)
            state <= (state == SEQ_TERMINAL) ? seq_reload(freq) : seq_next(state);
    end

    // R8: the sequence never reaches the all-zero lock-up state
    assert_no_lockup_R8: assert property (@(posedge clk) disable iff (rst)
        state != '0);

    // R7: without a tick the counter holds
    assert_hold_without_tick_R7: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(state));

endmodule

// File: rtl/tone_channel.sv
module tone_channel
    import tone_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable_i,
    input  logic       slow_tick_i,
    input  logic       fast_tick_i,
    input  logic [1:0] src_sel_i,
    input  logic       octave_i,
    input  logic [6:0] freq_i,
    output logic       tone_o
);
    tick_chain_t chain;
    logic        run;

    assign run = enable_i && !rst;

    tone_src_mux #(.SLOW_DIV(2), .HI_DIV(FAST_DIV)) u_mux (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .slow_tick (slow_tick_i),
        .fast_tick (fast_tick_i),
        .sel       (src_sel_e'(src_sel_i)),
        .src_tick  (chain.src)
    );

    tone_octave #(.DIV(OCT_DIV)) u_oct (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .octave   (octave_i),
        .in_tick  (chain.src),
        .out_tick (chain.scaled)
    );

    tone_seq_div u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (chain.scaled),
        .freq (seq_t'(freq_i)),
        .term (chain.term)
    );

    always_ff @(posedge clk) begin
        if (rst || !enable_i)
            tone_o <= 1'b0;
        else if (chain.term)
            tone_o <= ~tone_o;
    end

    // R9: a cleared enable silences the output at the next edge
    assert_disable_low_R9: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> !tone_o);

    // R7: a terminal event flips the output
    assert_term_toggles_R7: assert property (@(posedge clk) disable iff (rst)
        (enable_i && chain.term) |=> (tone_o != $past(tone_o)));

    // R11: no strobe, no change
    assert_quiet_stable_R11: assert property (@(posedge clk) disable iff (rst)
        (enable_i && !slow_tick_i && !fast_tick_i) |=> $stable(tone_o));

endmodule

// File: tb/tone_channel_bench.sv
module tone_channel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable_i = 1'b0;
    logic       slow_tick_i = 1'b0;
    logic       fast_tick_i = 1'b0;
    logic [1:0] src_sel_i = 2'b00;
    logic       octave_i = 1'b0;
    logic [6:0] freq_i = 7'h7F;
    logic       tone_o;

    int checks = 0;
    int errors = 0;
    string req = "R1";
    bit done = 1'b0;

    tone_channel u_tone_channel (
        .clk(clk), .rst(rst), .enable_i(enable_i),
        .slow_tick_i(slow_tick_i), .fast_tick_i(fast_tick_i),
        .src_sel_i(src_sel_i), .octave_i(octave_i),
        .freq_i(freq_i), .tone_o(tone_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    int m_slow = 0, m_fast = 0, m_oct = 0, m_seq = 127, m_tone = 0;

    function automatic int reload_of(input int w);
        return (w == 0) ? 127 : w;
    endfunction

    always @(posedge clk) begin
        int t;
        int s;
        if (rst || !enable_i) begin
            m_slow = 0; m_fast = 0; m_oct = 0; m_tone = 0;
            m_seq = reload_of(int'(freq_i));
        end else begin
            case (src_sel_i)
                2'b00:   t = int'(slow_tick_i);
                2'b01:   t = (slow_tick_i && m_slow == 1) ? 1 : 0;
                2'b10:   t = int'(fast_tick_i);
                default: t = (fast_tick_i && m_fast == 15) ? 1 : 0;
            endcase
            if (slow_tick_i) m_slow = (m_slow + 1) % 2;
            if (fast_tick_i) m_fast = (m_fast + 1) % 16;
            s = t;
            if (octave_i) s = (t == 1 && m_oct == 7) ? 1 : 0;
            if (t == 1) m_oct = (m_oct + 1) % 8;
            if (s == 1) begin
                if (m_seq == 127) begin
                    m_seq = reload_of(int'(freq_i));
                    m_tone = 1 - m_tone;
                end else begin
                    m_seq = ((m_seq << 1) & 127) | (((m_seq >> 6) ^ (m_seq >> 5)) & 1);
                end
            end
        end
    end

    task automatic check(input bit ok, input string r, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
        end
    endtask

    // One cycle: compare on the falling edge, then drive the next inputs
    task automatic step(input bit slow, input bit fast);
        @(negedge clk);
        check(tone_o === m_tone[0], req, int'(tone_o), m_tone);
        slow_tick_i = slow;
        fast_tick_i = fast;
    endtask

    task automatic run_random(input int n, input int slow_pct, input int fast_pct);
        for (int i = 0; i < n; i++)
            step($urandom_range(99) < slow_pct, $urandom_range(99) < fast_pct);
    endtask

    task automatic restart;
        @(negedge clk);
        enable_i = 1'b0; slow_tick_i = 1'b0; fast_tick_i = 1'b0;
        @(negedge clk);
        enable_i = 1'b1;
    endtask

    // Count toggles over n cycles with the given strobes held high
    task automatic count_toggles(input int n, input bit slow, input bit fast, output int cnt);
        logic prev;
        cnt = 0;
        slow_tick_i = slow; fast_tick_i = fast;
        prev = tone_o;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(tone_o === m_tone[0], req, int'(tone_o), m_tone);
            if (tone_o !== prev) cnt++;
            prev = tone_o;
        end
        slow_tick_i = 1'b0; fast_tick_i = 1'b0;
    endtask

    initial begin
        int tg;
        logic snap;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(tone_o === 1'b0, "R1", int'(tone_o), 0);
        rst = 1'b0;
        step(0, 0);
        check(tone_o === 1'b0, "R1", int'(tone_o), 0);

        // R7: word 7F toggles on every tick
        req = "R7"; src_sel_i = 2'b00; octave_i = 1'b0; freq_i = 7'h7F;
        restart();
        count_toggles(20, 1, 0, tg);
        check(tg == 20, "R7", tg, 20);
        freq_i = 7'h7E; run_random(200, 70, 0);
        freq_i = 7'h3A; run_random(400, 80, 0);

        // R2: slow source direct
        req = "R2"; freq_i = 7'h7C; restart(); run_random(500, 60, 40);

        // R3: slow source halved
        req = "R3"; src_sel_i = 2'b01; freq_i = 7'h79; restart(); run_random(600, 60, 40);

        // R4: fast source direct
        req = "R4"; src_sel_i = 2'b10; freq_i = 7'h55; restart(); run_random(800, 40, 70);

        // R5: fast source over sixteen, 160 strobes give 10 toggles
        req = "R5"; src_sel_i = 2'b11; freq_i = 7'h7F; restart();
        count_toggles(160, 0, 1, tg);
        check(tg == 10, "R5", tg, 10);
        freq_i = 7'h7D; run_random(2000, 30, 90);

        // R6: octave prescaler, 80 ticks give 10 toggles
        req = "R6"; src_sel_i = 2'b00; octave_i = 1'b1; freq_i = 7'h7F; restart();
        count_toggles(80, 1, 0, tg);
        check(tg == 10, "R6", tg, 10);
        freq_i = 7'h7B; run_random(1500, 80, 20);
        octave_i = 1'b0; run_random(300, 80, 20);

        // R8: zero word acts as all-ones
        req = "R8"; freq_i = 7'h00; restart();
        count_toggles(12, 1, 0, tg);
        check(tg == 12, "R8", tg, 12);

        // R10: word changes mid-period
        req = "R10"; freq_i = 7'h40; restart();
        for (int k = 0; k < 20; k++) begin
            run_random(37, 90, 50);
            freq_i = 7'($urandom_range(127));
        end
        src_sel_i = 2'b01; run_random(400, 90, 50);

        // R9: disable forces low
        req = "R9"; src_sel_i = 2'b00; freq_i = 7'h7F; restart();
        step(1, 0); step(1, 0); step(1, 0);
        @(negedge clk); enable_i = 1'b0; slow_tick_i = 1'b1;
        @(negedge clk);
        check(tone_o === 1'b0, "R9", int'(tone_o), 0);
        run_random(10, 100, 100);
        check(tone_o === 1'b0, "R9", int'(tone_o), 0);
        enable_i = 1'b1; run_random(300, 50, 50);

        // R11: no strobes, output frozen
        req = "R11"; freq_i = 7'h7F; src_sel_i = 2'b10;
        count_toggles(3, 0, 1, tg);
        snap = tone_o;
        run_random(50, 0, 0);
        check(tone_o === snap, "R11", int'(tone_o), int'(snap));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule